// File: doc/BRIEF.md
# UART Modem Status Register

This block keeps the modem-handshake state of one serial channel and presents it as an 8-bit status word on a host read port. Four active-low handshake pins (clear to send, data set ready, ring indicator, carrier detect) pass through a synchroniser. The block reports each line's asserted level and, for each line, a sticky change flag. One of these flags records ring-indicator trailing edges only. A modem-status interrupt request is raised while any flag is set and the interrupt enable is high.

The host reads by holding `rd_i` high for one or more cycles. The flags are cleared when the strobe falls. Events that arrive while the strobe is high are held back and resolved at that trailing edge. In loopback mode the external pins are ignored and the four line levels are taken from the modem-control output bits supplied on the control inputs. Writes to those bits can therefore raise the interrupt without any pin activity.

Top module: `uart_modem_status`

## Requirements
- R1: `status_o[7:4]` carry the asserted levels of carrier detect, ring, data set ready and clear to send (bit 7 down to bit 4). Outside loopback each level is the inverse of its pin (`dcd_ni`, `ri_ni`, `dsr_ni`, `cts_ni`). `status_o[3:0]` are the flags: bit 3 carrier-detect change, bit 2 ring trailing edge, bit 1 data-set-ready change, bit 0 clear-to-send change.
- R2: Bits 0, 1 and 3 set when the level of their line changes in either direction, and stay set until cleared by a read.
- R3: Bit 2 sets only when the ring level (bit 6) goes from 1 to 0. A ring level going from 0 to 1 leaves bit 2 unchanged.
- R4: When `rd_i` falls after a read with no event during it, bits 3:0 read 0. Bits 7:4 are not affected by a read.
- R5: While `rd_i` is high, bits 3:0 do not change. An event whose flag was clear before the read sets that flag once `rd_i` falls.
- R6: If a flag was set before the read and its event occurs again while `rd_i` is high, the flag reads 0 after `rd_i` falls.
- R7: With `loop_i` high, bits 7:4 equal {`out2_i`, `out1_i`, `dtr_i`, `rts_i`} and the pin inputs have no effect on `status_o`.
- R8: In loopback, changes of `rts_i`, `dtr_i`, `out1_i` and `out2_i` set the flags under the rules of R2 and R3.
- R9: `irq_o` is high exactly when `msi_en_i` is high and any of `status_o[3:0]` is set, so it drops after a read clears the flags.
- R10: After reset, bits 3:0 are 0 and bits 7:4 show the pin levels held during reset, with no flag raised by the synchroniser filling.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cts_ni | input | 1 | Clear-to-send pin, active low, asynchronous |
| dsr_ni | input | 1 | Data-set-ready pin, active low, asynchronous |
| ri_ni | input | 1 | Ring-indicator pin, active low, asynchronous |
| dcd_ni | input | 1 | Carrier-detect pin, active low, asynchronous |
| loop_i | input | 1 | Loopback select from the modem control register |
| rts_i | input | 1 | Request-to-send control bit |
| dtr_i | input | 1 | Data-terminal-ready control bit |
| out1_i | input | 1 | General output 1 control bit |
| out2_i | input | 1 | General output 2 control bit |
| msi_en_i | input | 1 | Modem-status interrupt enable |
| rd_i | input | 1 | Read strobe, high for the duration of a host read |
| status_o | output | 8 | Status word: line levels in 7:4, flags in 3:0 |
| irq_o | output | 1 | Modem-status interrupt request |

## Verification
The hardest case to reach is an event that lands inside an open read strobe. This matters most when the event hits a flag that is already set, because the flag must then clear rather than survive. The stimulus holds `rd_i` high across a pin or control change and lets the synchroniser settle inside the strobe. It checks that the flags stay frozen, then drops the strobe and compares against the set-or-toggle outcome. Random steps mix these reads with loopback switching, so the event source during a read is sometimes a pin and sometimes a control bit.

// File: rtl/msr_pkg.sv
package msr_pkg;
  localparam int unsigned NUM_LINES = 4;
  // line index inside the level/flag nibbles
  localparam int unsigned LN_CTS = 0;
  localparam int unsigned LN_DSR = 1;
  localparam int unsigned LN_RI  = 2;
  localparam int unsigned LN_DCD = 3;

  typedef struct packed {
    logic dcd;
    logic ri;
    logic dsr;
    logic cts;
  } modem_lines_t;
endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
  parameter int unsigned WIDTH = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= {STAGES{RST_VAL}};
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/msr_src_sel.sv
module msr_src_sel #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             loop_i,
  input  logic [WIDTH-1:0] pins_sync_n_i,
  input  logic [WIDTH-1:0] ctrl_i,
  output logic [WIDTH-1:0] lvl_o
);
  // pins are active low, control bits active high
  assign lvl_o = loop_i ? ctrl_i : ~pins_sync_n_i;
endmodule

// File: rtl/msr_delta.sv
module msr_delta #(
  parameter int unsigned NLINES = 4,
  parameter int unsigned TRAIL_IDX = 2,
  parameter int unsigned SETTLE_CYCLES = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NLINES-1:0] lvl_i,
  input  logic              rd_i,
  output logic [NLINES-1:0] delta_o
);
  localparam int unsigned CW = $clog2(SETTLE_CYCLES + 1);

  logic [NLINES-1:0] prev_q, delta_q, pend_q, evt;
  logic [CW-1:0]     settle_q;
  logic              settled, rd_q, rd_fall;

  for (genvar i = 0; i < NLINES; i++) begin : g_evt
    if (i == TRAIL_IDX) begin : g_trail
      assign evt[i] = prev_q[i] & ~lvl_i[i];
    end else begin : g_any
      assign evt[i] = prev_q[i] ^ lvl_i[i];
    end
  end

  assign settled = (settle_q == CW'(SETTLE_CYCLES));
  assign rd_fall = rd_q & ~rd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= '0;
      delta_q  <= '0;
      pend_q   <= '0;
      rd_q     <= 1'b0;
      settle_q <= '0;
    end else begin
      rd_q   <= rd_i;
      prev_q <= lvl_i;
      if (!settled) begin
        settle_q <= settle_q + CW'(1);
      end else if (rd_i) begin
        pend_q <= pend_q | evt;
      end else if (rd_fall) begin
        // repeated event on a set flag toggles it clear
        delta_q <= (pend_q | evt) & ~delta_q;
        pend_q  <= '0;
      end else begin
        delta_q <= delta_q | evt;
      end
    end
  end

  assign delta_o = delta_q;
endmodule

// File: rtl/uart_modem_status.sv
module uart_modem_status
  import msr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cts_ni,
  input  logic       dsr_ni,
  input  logic       ri_ni,
  input  logic       dcd_ni,
  input  logic       loop_i,
  input  logic       rts_i,
  input  logic       dtr_i,
  input  logic       out1_i,
  input  logic       out2_i,
  input  logic       msi_en_i,
  input  logic       rd_i,
  output logic [7:0] status_o,
  output logic       irq_o
);
  localparam int unsigned SETTLE = SYNC_STAGES + 1;

  modem_lines_t pins_n, pins_sync_n, ctrl, lvl;
  logic [NUM_LINES-1:0] delta;

  assign pins_n = '{dcd: dcd_ni, ri: ri_ni, dsr: dsr_ni, cts: cts_ni};
  assign ctrl   = '{dcd: out2_i, ri: out1_i, dsr: dtr_i, cts: rts_i};

  msr_sync #(
    .WIDTH  (NUM_LINES),
    .STAGES (SYNC_STAGES),
    .RST_VAL({NUM_LINES{1'b1}})
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_n),
    .q_o   (pins_sync_n)
  );

  msr_src_sel #(
    .WIDTH(NUM_LINES)
  ) u_sel (
    .loop_i       (loop_i),
    .pins_sync_n_i(pins_sync_n),
    .ctrl_i       (ctrl),
    .lvl_o        (lvl)
  );

  msr_delta #(
    .NLINES       (NUM_LINES),
    .TRAIL_IDX    (LN_RI),
    .SETTLE_CYCLES(SETTLE)
  ) u_delta (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (lvl),
    .rd_i   (rd_i),
    .delta_o(delta)
  );

  assign status_o = {lvl, delta};
  assign irq_o    = msi_en_i & (|delta);
endmodule

// File: rtl/uart_modem_status_chk.sv
module uart_modem_status_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       loop_i,
  input logic       rts_i,
  input logic       dtr_i,
  input logic       out1_i,
  input logic       out2_i,
  input logic       msi_en_i,
  input logic       rd_i,
  input logic [7:0] status_o,
  input logic       irq_o
);
  p_irq_flags_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (msi_en_i && (|status_o[3:0])));

  p_loop_levels_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loop_i |-> (status_o[7:4] == {out2_i, out1_i, dtr_i, rts_i}));

  p_hold_in_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_i) |-> $stable(status_o[3:0]));

  p_set_flag_cleared_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rd_i) && !rd_i) |=> ((status_o[3:0] & $past(status_o[3:0])) == 4'h0));

  p_trail_only_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(status_o[2]) && !$past(rd_i, 2)) |-> ($past(status_o[6], 2) && !$past(status_o[6])));
endmodule

bind uart_modem_status uart_modem_status_chk u_chk (.*);

// File: tb/uart_modem_status_tb.sv
`timescale 1ns/1ps
module uart_modem_status_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] pins = 4'hF;   // {dcd_n, ri_n, dsr_n, cts_n}
  logic [3:0] ctrl = 4'h0;   // {out2, out1, dtr, rts}
  logic loop = 1'b0, msi_en = 1'b0, rd = 1'b0;
  logic [7:0] status;
  logic irq;

  int vectors = 0, fails = 0;
  logic [3:0] exp_lvl = 4'h0, exp_delta = 4'h0, pend = 4'h0;
  bit in_read = 0;

  always #10 clk = ~clk;

  uart_modem_status u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cts_ni(pins[0]), .dsr_ni(pins[1]), .ri_ni(pins[2]), .dcd_ni(pins[3]),
    .loop_i(loop), .rts_i(ctrl[0]), .dtr_i(ctrl[1]), .out1_i(ctrl[2]), .out2_i(ctrl[3]),
    .msi_en_i(msi_en), .rd_i(rd), .status_o(status), .irq_o(irq)
  );

  function automatic logic [3:0] lvl_of(logic [3:0] p, logic l, logic [3:0] c);
    return l ? c : ~p;
  endfunction

  function automatic logic [3:0] evt_of(logic [3:0] o, logic [3:0] n);
    logic [3:0] e;
    e = o ^ n;
    e[2] = o[2] & ~n[2];
    return e;
  endfunction

  task automatic check(string req);
    logic [7:0] es;
    logic ei;
    es = {exp_lvl, exp_delta};
    ei = msi_en & (|exp_delta);
    vectors++;
    if (status !== es || irq !== ei) begin
      fails++;
      $display("FAIL %s: status=%h irq=%b expected status=%h irq=%b", req, status, irq, es, ei);
    end
  endtask

  task automatic change(logic [3:0] np, logic nl, logic [3:0] nc);
    logic [3:0] nlvl, e;
    nlvl = lvl_of(np, nl, nc);
    e = evt_of(exp_lvl, nlvl);
    if (in_read) pend |= e;
    else exp_delta |= e;
    exp_lvl = nlvl;
    @(negedge clk);
    pins = np; loop = nl; ctrl = nc;
    repeat (6) @(negedge clk);
  endtask

  task automatic do_read();
    @(negedge clk) rd = 1'b1;
    repeat (2) @(negedge clk);
    rd = 1'b0;
    exp_delta = 4'h0;
    repeat (2) @(negedge clk);
  endtask

  task automatic read_with_change(logic [3:0] np, logic nl, logic [3:0] nc, string req);
    @(negedge clk) rd = 1'b1;
    in_read = 1; pend = 4'h0;
    change(np, nl, nc);
    check({req, " R5 held during read"});
    rd = 1'b0;
    exp_delta = pend & ~exp_delta;
    in_read = 0;
    repeat (2) @(negedge clk);
    check({req, " trailing edge"});
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5A17);
    // R10: pins held during reset, cts asserted
    pins = 4'b1110;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    exp_lvl = lvl_of(pins, 1'b0, ctrl);
    exp_delta = 4'h0;
    repeat (8) @(negedge clk);
    check("R10 R1 reset state");
    msi_en = 1'b1;
    check("R9 enable with no flags");
    // R2: cts deasserts, dsr asserts, dcd asserts
    change(4'b1111, 0, ctrl); check("R2 cts change");
    change(4'b0101, 0, ctrl); check("R2 dsr and dcd change");
    do_read(); check("R4 read clears flags");
    // R3: ring assert then deassert
    change(4'b0001, 0, ctrl); check("R3 ring assert no flag");
    change(4'b0101, 0, ctrl); check("R3 ring trailing edge");
    msi_en = 1'b0; @(negedge clk); check("R9 enable low masks irq");
    msi_en = 1'b1; @(negedge clk); check("R9 irq with flag");
    do_read(); check("R9 R4 irq drops after read");
    // R5 / R6: set cts flag, then cts again plus dsr during read
    change(4'b0100, 0, ctrl); check("R2 cts set before read");
    read_with_change(4'b0111, 0, ctrl, "R6 R5 repeat clears, new sets");
    do_read(); check("R4 clear after resolve");
    // R7 / R8: loopback
    change(pins, 1, 4'b0000); check("R7 enter loopback");
    do_read();
    change(4'b0000, 1, 4'b0000); check("R7 pins ignored in loopback");
    change(pins, 1, 4'b0101); check("R8 control writes raise flags");
    change(pins, 1, 4'b0001); check("R8 R3 out1 trailing edge");
    do_read(); check("R4 loopback read");
    change(pins, 0, ctrl); check("R1 leave loopback");
    do_read();
    // random mix
    for (int it = 0; it < 400; it++) begin
      int unsigned k;
      k = $urandom_range(0, 5);
      case (k)
        0: if (!loop) change(4'($urandom), 0, ctrl); else change(4'($urandom), 1, ctrl);
        1: change(pins, ~loop, 4'($urandom));
        2: change(pins, loop, 4'($urandom));
        3: do_read();
        4: if ($urandom_range(0, 1) == 0) read_with_change(4'($urandom), loop, ctrl, "R6 random pins");
           else read_with_change(pins, loop, 4'($urandom), "R8 random ctrl");
        default: begin msi_en = 1'($urandom); @(negedge clk); end
      endcase
      check("R2 R7 R9 random step");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule